// File: doc/BRIEF.md
# ADC Analog Front-End Power-Up Sequencer

This block turns on the analog front end of an on-chip ADC in a fixed order. A power-up request first switches on the band gap and the reference together. The sequencer then waits a long settling interval, which is in the millisecond range. Next it switches on the converter core and waits a short settling interval, which is in the microsecond range. Only after both waits does it raise `ready`.

Conversion requests pass through a gate. A request made while `ready` is high becomes a one-cycle start strobe for the converter. A request made at any other time is discarded, not queued, and it sets a sticky error flag.

A power-down request turns every enable off in the same cycle from any state, with no ordering. Both settling intervals are counted in clock cycles. Their defaults come from the `CLK_KHZ` parameter and the typical settling times: 8 ms for the band gap and reference, and 50 µs for the core.

All pins are plain control and status pins. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. A conversion request lasts one cycle and is either accepted or dropped in that cycle.

Top module: `adc_pwr_seq`

## Requirements
- R1: `core_en` is never high unless `bg_en` and `ref_en` are both high. A `pwr_up_req` sampled while everything is off, and without `pwr_dn_req`, raises `bg_en` and `ref_en` together one cycle later.
- R2: `core_en` rises exactly `BG_CYCLES` clock cycles after `bg_en` rises.
- R3: `ready` rises exactly `CORE_CYCLES` clock cycles after `core_en` rises.
- R4: A sampled `pwr_dn_req` drives `bg_en`, `ref_en`, `core_en` and `ready` low on the next cycle, from any state. It takes priority over a `pwr_up_req` in the same cycle.
- R5: `ready` is never high unless `core_en` is high.
- R6: A `conv_req` sampled while `ready` is high and `pwr_dn_req` is low produces `conv_start` high for exactly the next cycle. Each cycle of request produces one cycle of strobe.
- R7: A `conv_req` sampled while `ready` is low, or in the same cycle as `pwr_dn_req`, produces no `conv_start`. It sets `early_req_err`, which stays high from the next cycle on.
- R8: `early_req_err` is low after reset. A `pwr_up_req` sampled without a simultaneous `conv_req` clears it on the next cycle.
- R9: A `pwr_up_req` sampled while powered up or settling is ignored. It neither restarts nor shortens either settling interval.
- R10: During and after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_up_req | input | 1 | Request to start the power-up sequence |
| pwr_dn_req | input | 1 | Request to switch everything off at once |
| conv_req | input | 1 | Request to start one conversion |
| bg_en | output | 1 | Band gap enable |
| ref_en | output | 1 | Reference enable |
| core_en | output | 1 | Converter core enable |
| ready | output | 1 | Both settling intervals have elapsed |
| conv_start | output | 1 | One-cycle gated conversion start strobe |
| early_req_err | output | 1 | Sticky flag for a dropped, premature conversion request |

## Verification
The checker assumes the three request inputs are synchronous to `clk` and carry no unknown values once reset has been released. It also assumes both settling parameters are at least one cycle. Its window counters treat a rise of `core_en` or `ready` as reachable only through the preceding settling state.

The bench overrides the intervals with short cycle counts. It changes inputs only on the falling edge, so every request is a clean whole-cycle level. It issues power-up requests in the middle of both settling intervals to confirm they are ignored.

// File: rtl/adc_pwr_seq_pkg.sv
package adc_pwr_seq_pkg;
  typedef enum logic [1:0] {
    PS_OFF       = 2'd0,
    PS_BGAP_WAIT = 2'd1,
    PS_CORE_WAIT = 2'd2,
    PS_READY     = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  // Fires on the LIMIT-th cycle of an uninterrupted run.
  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (done)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_up_req,
  input  logic       pwr_dn_req,
  input  logic       bgap_done,
  input  logic       core_done,
  output pwr_state_e state
);
  pwr_state_e nxt;

  always_comb begin
    nxt = state;
    if (pwr_dn_req) begin
      nxt = PS_OFF;
    end else begin
      unique case (state)
        PS_OFF:       if (pwr_up_req) nxt = PS_BGAP_WAIT;
        PS_BGAP_WAIT: if (bgap_done)  nxt = PS_CORE_WAIT;
        PS_CORE_WAIT: if (core_done)  nxt = PS_READY;
        PS_READY:     nxt = PS_READY;
        default:      nxt = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PS_OFF;
    else        state <= nxt;
  end
endmodule

// File: rtl/adc_conv_gate.sv
module adc_conv_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic pwr_up_req,
  input  logic pwr_dn_req,
  input  logic conv_req,
  output logic conv_start,
  output logic early_req_err
);
  logic accept;
  assign accept = ready && !pwr_dn_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_start    <= 1'b0;
      early_req_err <= 1'b0;
    end else begin
      conv_start <= conv_req && accept;
      // A premature request wins over a clearing power-up request.
      if (conv_req && !accept) early_req_err <= 1'b1;
      else if (pwr_up_req)     early_req_err <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_seq_pkg::*;
#(
  parameter int CLK_KHZ     = 100000,
  parameter int BG_CYCLES   = CLK_KHZ * 8,
  parameter int CORE_CYCLES = (CLK_KHZ * 50) / 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_up_req,
  input  logic pwr_dn_req,
  input  logic conv_req,
  output logic bg_en,
  output logic ref_en,
  output logic core_en,
  output logic ready,
  output logic conv_start,
  output logic early_req_err
);
  localparam int BG_LIM   = (BG_CYCLES   < 1) ? 1 : BG_CYCLES;
  localparam int CORE_LIM = (CORE_CYCLES < 1) ? 1 : CORE_CYCLES;

  pwr_state_e state;
  logic bgap_done, core_done;

  adc_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_up_req (pwr_up_req),
    .pwr_dn_req (pwr_dn_req),
    .bgap_done  (bgap_done),
    .core_done  (core_done),
    .state      (state)
  );

  adc_settle_timer #(.LIMIT(BG_LIM)) u_bgap_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == PS_BGAP_WAIT),
    .done  (bgap_done)
  );

  adc_settle_timer #(.LIMIT(CORE_LIM)) u_core_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == PS_CORE_WAIT),
    .done  (core_done)
  );

  assign bg_en   = (state != PS_OFF);
  assign ref_en  = (state != PS_OFF);
  assign core_en = (state == PS_CORE_WAIT) || (state == PS_READY);
  assign ready   = (state == PS_READY);

  adc_conv_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .ready         (ready),
    .pwr_up_req    (pwr_up_req),
    .pwr_dn_req    (pwr_dn_req),
    .conv_req      (conv_req),
    .conv_start    (conv_start),
    .early_req_err (early_req_err)
  );
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
  parameter int BG_CYCLES   = 8,
  parameter int CORE_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_up_req,
  input logic pwr_dn_req,
  input logic conv_req,
  input logic bg_en,
  input logic ref_en,
  input logic core_en,
  input logic ready,
  input logic conv_start,
  input logic early_req_err
);
  int bg_cnt, core_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !bg_en)  bg_cnt <= 0;
    else if (!core_en)     bg_cnt <= bg_cnt + 1;
    if (!rst_n || !core_en) core_cnt <= 0;
    else if (!ready)        core_cnt <= core_cnt + 1;
  end

  a_r1_core_after_bg: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> (bg_en && ref_en));

  a_r2_bg_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_en) |-> (bg_cnt == BG_CYCLES));

  a_r3_core_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (core_cnt == CORE_CYCLES));

  a_r4_dn_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn_req |=> (!bg_en && !ref_en && !core_en && !ready));

  a_r5_ready_needs_core: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> core_en);

  a_r6_start_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && ready && !pwr_dn_req) |=> conv_start);

  a_r7_early_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && (!ready || pwr_dn_req)) |=> (early_req_err && !conv_start));

  a_r8_up_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up_req && !conv_req) |=> !early_req_err);

  a_r9_stay_on: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_en && !pwr_dn_req) |=> bg_en);
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(
  .BG_CYCLES   (BG_LIM),
  .CORE_CYCLES (CORE_LIM)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pwr_up_req    (pwr_up_req),
  .pwr_dn_req    (pwr_dn_req),
  .conv_req      (conv_req),
  .bg_en         (bg_en),
  .ref_en        (ref_en),
  .core_en       (core_en),
  .ready         (ready),
  .conv_start    (conv_start),
  .early_req_err (early_req_err)
);

// File: tb/adc_pwr_seq_tb_top.sv
module adc_pwr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BG   = 20;
  localparam int CORE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_up_req = 1'b0, pwr_dn_req = 1'b0, conv_req = 1'b0;
  logic bg_en, ref_en, core_en, ready, conv_start, early_req_err;

  int n_checks = 0;
  int n_fail = 0;
  bit reported = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_pwr_seq #(.CLK_KHZ(1), .BG_CYCLES(BG), .CORE_CYCLES(CORE)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_up_req(pwr_up_req), .pwr_dn_req(pwr_dn_req),
    .conv_req(conv_req), .bg_en(bg_en), .ref_en(ref_en), .core_en(core_en),
    .ready(ready), .conv_start(conv_start), .early_req_err(early_req_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic int outs();
    return {bg_en, ref_en, core_en, ready, conv_start, early_req_err};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  // R10: everything low during and after reset
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    check(outs() == 0, "R10 in reset", outs(), 0);
    rst_n = 1'b1;
    step();
    check(outs() == 0, "R10 after reset", outs(), 0);
  endtask

  // R1, R2, R3, R5 (and R9 when poke is set)
  task automatic t_powerup(input bit poke);
    int bg_at = -1, core_at = -1, rdy_at = -1;
    bit order_ok = 1'b1;
    bit pair_ok = 1'b1;
    pwr_up_req = 1'b1;
    step();
    pwr_up_req = 1'b0;
    check(early_req_err == 1'b0, "R8 cleared by power-up", early_req_err, 0);
    for (int k = 1; k <= BG + CORE + 10; k++) begin
      if (bg_en && bg_at < 0) bg_at = k;
      if (core_en && core_at < 0) core_at = k;
      if (ready && rdy_at < 0) rdy_at = k;
      if (bg_en != ref_en) pair_ok = 1'b0;
      if (core_en && !(bg_en && ref_en)) order_ok = 1'b0;
      if (ready && !core_en) order_ok = 1'b0;
      if (poke) pwr_up_req = (k == 3) || (k == BG + 2) || (k == BG + CORE + 3);
      step();
    end
    pwr_up_req = 1'b0;
    check(bg_at == 1, "R1 bg rises one cycle after request", bg_at, 1);
    check(pair_ok, "R1 bg and ref together", pair_ok, 1);
    check(order_ok, "R1 R5 enable ordering", order_ok, 1);
    check(core_at - bg_at == BG, poke ? "R9 bg window with pokes" : "R2 bg window",
          core_at - bg_at, BG);
    check(rdy_at - core_at == CORE, poke ? "R9 core window with pokes" : "R3 core window",
          rdy_at - core_at, CORE);
    check(ready == 1'b1, "R5 ready at end", ready, 1);
  endtask

  // R6: gated start strobes while ready
  task automatic t_conv_ready();
    conv_req = 1'b1; step(); conv_req = 1'b0;
    check(conv_start == 1'b1, "R6 single strobe", conv_start, 1);
    step();
    check(conv_start == 1'b0, "R6 strobe is one cycle", conv_start, 0);
    conv_req = 1'b1; step();
    check(conv_start == 1'b1, "R6 held request cycle 1", conv_start, 1);
    step(); conv_req = 1'b0;
    check(conv_start == 1'b1, "R6 held request cycle 2", conv_start, 1);
    step();
    check(conv_start == 1'b0, "R6 strobe ends", conv_start, 0);
    check(early_req_err == 1'b0, "R7 no error while ready", early_req_err, 0);
  endtask

  // R4, R7: power-down with a simultaneous request from READY
  task automatic t_dn_from_ready();
    pwr_dn_req = 1'b1; conv_req = 1'b1; step();
    pwr_dn_req = 1'b0; conv_req = 1'b0;
    check({bg_en, ref_en, core_en, ready} == 0, "R4 off from ready",
          {bg_en, ref_en, core_en, ready}, 0);
    check(conv_start == 1'b0, "R7 no strobe with power-down", conv_start, 0);
    check(early_req_err == 1'b1, "R7 error with power-down", early_req_err, 1);
    repeat (3) step();
    check(bg_en == 1'b0, "R4 stays off", bg_en, 0);
  endtask

  // R7, R8, R4: premature requests while off, up+down together
  task automatic t_premature_off();
    conv_req = 1'b1; step(); conv_req = 1'b0;
    check(conv_start == 1'b0, "R7 dropped while off", conv_start, 0);
    check(early_req_err == 1'b1, "R7 error set", early_req_err, 1);
    repeat (4) step();
    check(early_req_err == 1'b1, "R7 error sticky", early_req_err, 1);
    pwr_up_req = 1'b1; pwr_dn_req = 1'b1; step();
    pwr_up_req = 1'b0; pwr_dn_req = 1'b0;
    check(bg_en == 1'b0, "R4 down beats up", bg_en, 0);
    check(early_req_err == 1'b0, "R8 cleared by power-up request", early_req_err, 1'b0);
    conv_req = 1'b1; step(); conv_req = 1'b0;
    check(early_req_err == 1'b1, "R7 error set again", early_req_err, 1);
  endtask

  // R4, R7: power-down and premature request during settling
  task automatic t_dn_settling();
    pwr_up_req = 1'b1; step(); pwr_up_req = 1'b0;
    repeat (5) step();
    conv_req = 1'b1; step(); conv_req = 1'b0;
    check(conv_start == 1'b0, "R7 dropped while settling", conv_start, 0);
    check(early_req_err == 1'b1, "R7 error while settling", early_req_err, 1);
    check(bg_en == 1'b1 && core_en == 1'b0, "R2 still settling", {bg_en, core_en}, 2);
    pwr_dn_req = 1'b1; step(); pwr_dn_req = 1'b0;
    check({bg_en, ref_en, core_en, ready} == 0, "R4 off from settling",
          {bg_en, ref_en, core_en, ready}, 0);
  endtask

  initial begin
    t_reset();
    t_premature_off();
    t_powerup(1'b0);
    t_conv_ready();
    t_dn_from_ready();
    t_dn_settling();
    t_powerup(1'b1);
    t_conv_ready();
    repeat (2) step();
    report();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end
endmodule